// File: doc/BRIEF.md
# Bus Arbitration State Machine

This block decides, one bus clock at a time, whether the processor side of a chip owns a shared external bus. An outside agent signals ownership through a grant input. The processor core raises a request whenever it needs a bus cycle. The block answers with three outputs: a bus-driven indication, a three-state enable for the address, data and control pins, and, when it is wired for it, a bus request towards an external arbiter.

Four arbitration states are tracked: reset, implicit ownership, explicit ownership and external ownership. In implicit ownership the grant is held but nothing is driven. Explicit ownership is entered only when grant and a core request are both present. Once in explicit ownership, the bus is given up only after any transfer in flight has completed. A mode input selects between a two-wire handshake, in which the request output stays low, and a three-wire handshake, in which the request output is used.

Top module: `bus_arbiter`

## Requirements
- R1: At the first rising clock edge where `hard_rst_i` or `wdog_rst_i` is high, the state becomes reset (`arb_state_o` = 0). While in reset, `bus_driven_o`, `bus_oe_o` and `bus_req_o` are all 0.
- R2: At an edge where both resets are low and the state is reset, the state becomes implicit (1) if `grant_i` is high, or external (3) if it is low.
- R3: In the implicit state, `bus_driven_o`, `bus_oe_o` and `cycle_ok_o` are 0.
- R4: At an edge where the state is implicit and both `grant_i` and `core_req_i` are high, the state becomes explicit (2). `bus_driven_o` and `bus_oe_o` both go to 1 at that same edge.
- R5: At an edge where the state is implicit and `grant_i` is low, the state becomes external (3).
- R6: In the explicit state with `grant_i` low, the state stays explicit and keeps driving while `xfer_busy_i` is high. At the first edge with `xfer_busy_i` low, it moves to external, and `bus_driven_o` and `bus_oe_o` drop to 0.
- R7: At an edge where the state is external and `grant_i` is high, the state becomes implicit (1).
- R8: With `three_wire_i` = 1, `bus_req_o` equals `core_req_i` AND NOT `grant_i`, combinationally, in every state except reset. With `three_wire_i` = 0, `bus_req_o` is always 0.
- R9: `cycle_ok_o` is 1 exactly when the state is explicit and `grant_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; all state changes on rising edge |
| hard_rst_i | input | 1 | Hardware reset, active high, synchronous |
| wdog_rst_i | input | 1 | Watchdog reset, active high, synchronous |
| grant_i | input | 1 | Bus grant from the external side, active high |
| core_req_i | input | 1 | Internal request for a bus cycle from the core |
| xfer_busy_i | input | 1 | A bus transfer is in progress |
| three_wire_i | input | 1 | 1 selects three-wire handshake, 0 two-wire |
| bus_driven_o | output | 1 | The processor side is driving the bus |
| bus_oe_o | output | 1 | Three-state enable for address, data and control |
| bus_req_o | output | 1 | Bus request towards an external arbiter |
| cycle_ok_o | output | 1 | A new bus cycle may be started |
| arb_state_o | output | 2 | Current arbitration state: 0 reset, 1 implicit, 2 explicit, 3 external |

## Verification
The hardest situation to reach is grant being withdrawn while a transfer is still running. This needs explicit ownership first, which in turn needs the implicit state with grant and a request. The stimulus walks the block through reset, then implicit, then explicit. It then drops grant while holding the busy input high for several clocks, before it lets the transfer complete. The watchdog reset is also applied from explicit ownership, to show that it overrides a live ownership.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    localparam int ARB_STATE_W = 2;

    typedef enum logic [ARB_STATE_W-1:0] {
        ARB_RESET    = 2'd0,
        ARB_IMPLICIT = 2'd1,
        ARB_EXPLICIT = 2'd2,
        ARB_EXTERNAL = 2'd3
    } arb_state_e;

    typedef struct packed {
        arb_state_e st;
        logic       drv;
        logic       oe;
    } arb_reg_t;

endpackage

// File: rtl/arb_next_state.sv
module arb_next_state
    import bus_arb_pkg::*;
(
    input  arb_state_e st_q,
    input  logic       any_rst,
    input  logic       grant,
    input  logic       req,
    input  logic       busy,
    output arb_state_e st_d
);
    always_comb begin
        st_d = st_q;
        if (any_rst) begin
            st_d = ARB_RESET;
        end else begin
            unique case (st_q)
                ARB_RESET:    st_d = grant ? ARB_IMPLICIT : ARB_EXTERNAL;
                ARB_IMPLICIT: begin
                    if (!grant)
                        st_d = ARB_EXTERNAL;
                    else if (req)
                        st_d = ARB_EXPLICIT;
                end
                ARB_EXPLICIT: begin
                    if (!grant && !busy)
                        st_d = ARB_EXTERNAL;
                end
                ARB_EXTERNAL: begin
                    if (grant)
                        st_d = ARB_IMPLICIT;
                end
                default:      st_d = ARB_RESET;
            endcase
        end
    end
endmodule

// File: rtl/arb_req_gen.sv
module arb_req_gen
    import bus_arb_pkg::*;
(
    input  arb_state_e st_q,
    input  logic       three_wire,
    input  logic       grant,
    input  logic       req,
    output logic       bus_req
);
    always_comb begin
        bus_req = 1'b0;
        if (three_wire && st_q != ARB_RESET)
            bus_req = req && !grant;
    end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import bus_arb_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   hard_rst_i,
    input  logic                   wdog_rst_i,
    input  logic                   grant_i,
    input  logic                   core_req_i,
    input  logic                   xfer_busy_i,
    input  logic                   three_wire_i,
    output logic                   bus_driven_o,
    output logic                   bus_oe_o,
    output logic                   bus_req_o,
    output logic                   cycle_ok_o,
    output logic [ARB_STATE_W-1:0] arb_state_o
);
    arb_reg_t   r_d, r_q;
    arb_state_e st_next;
    logic       any_rst;

    assign any_rst = hard_rst_i | wdog_rst_i;

    arb_next_state u_next (
        .st_q    (r_q.st),
        .any_rst (any_rst),
        .grant   (grant_i),
        .req     (core_req_i),
        .busy    (xfer_busy_i),
        .st_d    (st_next)
    );

    arb_req_gen u_req (
        .st_q       (r_q.st),
        .three_wire (three_wire_i),
        .grant      (grant_i),
        .req        (core_req_i),
        .bus_req    (bus_req_o)
    );

    always_comb begin
        r_d     = r_q;
        r_d.st  = st_next;
        r_d.drv = (st_next == ARB_EXPLICIT);
        r_d.oe  = (st_next == ARB_EXPLICIT);
    end

    always_ff @(posedge clk_i) begin
        if (hard_rst_i) begin
            r_q.st  <= ARB_RESET;
            r_q.drv <= 1'b0;
            r_q.oe  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_driven_o = r_q.drv;
    assign bus_oe_o     = r_q.oe;
    assign arb_state_o  = r_q.st;
    assign cycle_ok_o   = (r_q.st == ARB_EXPLICIT) && grant_i;
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk (
    input logic       clk_i,
    input logic       hard_rst_i,
    input logic       wdog_rst_i,
    input logic       grant_i,
    input logic       core_req_i,
    input logic       xfer_busy_i,
    input logic       three_wire_i,
    input logic       bus_driven_o,
    input logic       bus_oe_o,
    input logic       bus_req_o,
    input logic       cycle_ok_o,
    input logic [1:0] arb_state_o
);
    p_wdog_entry_r1: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        wdog_rst_i |=> arb_state_o == 2'd0);

    p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        arb_state_o == 2'd0 |-> (!bus_driven_o && !bus_oe_o && !bus_req_o));

    p_exit_grant_r2: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        (arb_state_o == 2'd0 && !wdog_rst_i && grant_i) |=> arb_state_o == 2'd1);

    p_implicit_quiet_r3: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        arb_state_o == 2'd1 |-> (!bus_driven_o && !bus_oe_o && !cycle_ok_o));

    p_enter_explicit_r4: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        (arb_state_o == 2'd1 && !wdog_rst_i && grant_i && core_req_i)
        |=> (arb_state_o == 2'd2 && bus_driven_o && bus_oe_o));

    p_hold_busy_r6: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        (arb_state_o == 2'd2 && !wdog_rst_i && xfer_busy_i) |=> arb_state_o == 2'd2);

    p_ext_to_impl_r7: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        (arb_state_o == 2'd3 && !wdog_rst_i && grant_i) |=> arb_state_o == 2'd1);

    p_two_wire_r8: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        !three_wire_i |-> !bus_req_o);

    p_req_no_grant_r8: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        bus_req_o |-> (!grant_i && core_req_i));

    p_cycle_ok_r9: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        cycle_ok_o |-> (bus_driven_o && grant_i));
endmodule

bind bus_arbiter bus_arbiter_chk chk_i (
    .clk_i        (clk_i),
    .hard_rst_i   (hard_rst_i),
    .wdog_rst_i   (wdog_rst_i),
    .grant_i      (grant_i),
    .core_req_i   (core_req_i),
    .xfer_busy_i  (xfer_busy_i),
    .three_wire_i (three_wire_i),
    .bus_driven_o (bus_driven_o),
    .bus_oe_o     (bus_oe_o),
    .bus_req_o    (bus_req_o),
    .cycle_ok_o   (cycle_ok_o),
    .arb_state_o  (arb_state_o)
);

// File: tb/bus_arbiter_tb_top.sv
module bus_arbiter_tb_top;
    logic       clk_i = 1'b0;
    logic       hard_rst_i = 1'b1;
    logic       wdog_rst_i = 1'b0;
    logic       grant_i = 1'b0;
    logic       core_req_i = 1'b0;
    logic       xfer_busy_i = 1'b0;
    logic       three_wire_i = 1'b0;
    logic       bus_driven_o, bus_oe_o, bus_req_o, cycle_ok_o;
    logic [1:0] arb_state_o;

    int vectors = 0;
    int fails = 0;

    always #5 clk_i = ~clk_i;

    bus_arbiter dut_i (
        .clk_i        (clk_i),
        .hard_rst_i   (hard_rst_i),
        .wdog_rst_i   (wdog_rst_i),
        .grant_i      (grant_i),
        .core_req_i   (core_req_i),
        .xfer_busy_i  (xfer_busy_i),
        .three_wire_i (three_wire_i),
        .bus_driven_o (bus_driven_o),
        .bus_oe_o     (bus_oe_o),
        .bus_req_o    (bus_req_o),
        .cycle_ok_o   (cycle_ok_o),
        .arb_state_o  (arb_state_o)
    );

    task automatic step();
        @(posedge clk_i);
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        three_wire_i = 1'b1; core_req_i = 1'b1; grant_i = 1'b0;
        step(); step();
        chk("R1 state in reset", arb_state_o, 0);
        chk("R1 driven in reset", bus_driven_o, 0);
        chk("R1 oe in reset", bus_oe_o, 0);
        chk("R1 request in reset", bus_req_o, 0);
        core_req_i = 1'b0;
    endtask

    task automatic t_exit_reset();
        grant_i = 1'b0; hard_rst_i = 1'b0;
        step();
        chk("R2 exit without grant", arb_state_o, 3);
        hard_rst_i = 1'b1;
        step();
        chk("R1 hard reset from external", arb_state_o, 0);
        grant_i = 1'b1; hard_rst_i = 1'b0;
        step();
        chk("R2 exit with grant", arb_state_o, 1);
    endtask

    task automatic t_implicit_hold();
        core_req_i = 1'b0;
        step();
        chk("R3 implicit state held", arb_state_o, 1);
        chk("R3 implicit not driven", bus_driven_o, 0);
        chk("R3 implicit oe off", bus_oe_o, 0);
        chk("R3 implicit no cycle", cycle_ok_o, 0);
    endtask

    task automatic t_to_explicit();
        core_req_i = 1'b1;
        step();
        chk("R4 explicit entered", arb_state_o, 2);
        chk("R4 driven on entry", bus_driven_o, 1);
        chk("R4 oe on entry", bus_oe_o, 1);
        chk("R9 cycle allowed", cycle_ok_o, 1);
    endtask

    task automatic t_release_busy();
        core_req_i = 1'b0; xfer_busy_i = 1'b1; grant_i = 1'b0;
        #1;
        chk("R9 no cycle without grant", cycle_ok_o, 0);
        step();
        chk("R6 held while busy", arb_state_o, 2);
        chk("R6 still driving", bus_driven_o, 1);
        step(); step();
        chk("R6 held several cycles", arb_state_o, 2);
        xfer_busy_i = 1'b0;
        step();
        chk("R6 released to external", arb_state_o, 3);
        chk("R6 driven dropped", bus_driven_o, 0);
        chk("R6 oe dropped", bus_oe_o, 0);
    endtask

    task automatic t_request_out();
        three_wire_i = 1'b1; core_req_i = 1'b1; grant_i = 1'b0;
        #1;
        chk("R8 three-wire request", bus_req_o, 1);
        three_wire_i = 1'b0;
        #1;
        chk("R8 two-wire request low", bus_req_o, 0);
        three_wire_i = 1'b1; core_req_i = 1'b0;
        #1;
        chk("R8 no internal request", bus_req_o, 0);
        grant_i = 1'b1; core_req_i = 1'b1;
        #1;
        chk("R8 grant held no request", bus_req_o, 0);
        core_req_i = 1'b0;
    endtask

    task automatic t_ext_impl_ext();
        grant_i = 1'b1;
        step();
        chk("R7 external to implicit", arb_state_o, 1);
        grant_i = 1'b0;
        step();
        chk("R5 implicit to external", arb_state_o, 3);
    endtask

    task automatic t_watchdog();
        grant_i = 1'b1;
        step();
        core_req_i = 1'b1;
        step();
        chk("R4 explicit before watchdog", arb_state_o, 2);
        wdog_rst_i = 1'b1;
        step();
        chk("R1 watchdog enters reset", arb_state_o, 0);
        chk("R1 watchdog drops drive", bus_driven_o, 0);
        chk("R1 watchdog drops oe", bus_oe_o, 0);
        wdog_rst_i = 1'b0; core_req_i = 1'b0;
        step();
        chk("R2 exit after watchdog", arb_state_o, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        fails++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_exit_reset();
        t_implicit_hold();
        t_to_explicit();
        t_release_busy();
        t_request_out();
        t_ext_impl_ext();
        t_watchdog();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule